// File: doc/BRIEF.md
# Three-Window Data Address Mapper

This block turns a 16-bit processor data address into a wider physical address. It uses three programmable windows. Window 0 always begins at address zero. Windows 1 and 2 begin at start addresses held in registers. A window is defined only by where it begins: it runs until the next window begins, and the top window stops at a fixed limit. Each window has a 16-bit physical page number in units of 512 bytes. The physical address is that page's base plus the distance of the virtual address from the start of the window. Addresses at the limit and above are passed through unchanged, with the valid flag low.

The mapping registers are loaded through a byte-wide register port. The write is registered and the read is combinational. The same port holds a memory-select bit that tells the processor whether to run from read-only or writable program memory. Any change to that bit raises a single-cycle restart pulse. Translation is purely combinational, so the mapped address follows the virtual address in the same cycle.

Top module: `window_addr_mapper`

## Requirements
- R1: After reset, every register reads back as zero. The memory-select output and the restart pulse are both low.
- R2: The register offsets are: 0 control, 1 and 2 bank 0 page (low, high), 3 bank 1 start, 4 bank 2 start, 5 and 6 bank 1 page (low, high), 7 and 8 bank 2 page (low, high). A write to any of these is read back unchanged at the same offset.
- R3: A window start equals the start register's value with bit 0 cleared, shifted left by 8. Bit 0 of a start register has no effect on translation.
- R4: When the address is below the limit and below both window starts, bank_sel is 0 and pa = (page0 << 9) + va.
- R5: When start1 <= va < start2, bank_sel is 1 and pa = (page1 << 9) + (va - start1).
- R6: When start2 <= va < 0xF000, bank_sel is 2 and pa = (page2 << 9) + (va - start2).
- R7: Overlapping windows resolve to the higher bank number. If start1 >= start2, bank 1 is never selected. If both starts are equal, addresses from that start upward map to bank 2.
- R8: For va >= 0xF000, pa equals va zero-extended, pa_valid is 0 and bank_sel is 3. Below 0xF000, pa_valid is 1.
- R9: Bit 0 of the control register drives run_from_ram. A write whose bit 0 differs from the stored value raises restart_pulse for exactly the one cycle after the write edge. A write with the same bit 0 raises no pulse.
- R10: Offsets 9 to 15 read as zero. Writes to them change no register and raise no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr | input | 4 | Register offset |
| wr_data | input | 8 | Register write byte |
| rd_data | output | 8 | Combinational read byte at reg_addr |
| va | input | 16 | Virtual data address |
| pa | output | 26 | Physical address |
| pa_valid | output | 1 | High when va was translated through a window |
| bank_sel | output | 2 | Window used: 0, 1, 2, or 3 for pass-through |
| run_from_ram | output | 1 | Stored memory-select bit |
| restart_pulse | output | 1 | One-cycle pulse on change of the memory-select bit |

## Verification
The assertions assume that va and the register port are stable around the sampling edge. They also assume that a write to the control register is the only event that can change the memory-select bit. The bench changes inputs only on the falling edge and checks the combinational outputs one time unit later. It checks the restart pulse at the falling edge just after the write edge and again one cycle later. For every window check, the bench programs starts whose order is chosen on purpose: ordered, reversed and equal. This lets the priority rule be seen on its own.

// File: rtl/wmap_pkg.sv
package wmap_pkg;
    localparam int VA_W   = 16;
    localparam int PAGE_W = 16;

    typedef enum logic [1:0] {
        SEL_B0   = 2'd0,
        SEL_B1   = 2'd1,
        SEL_B2   = 2'd2,
        SEL_PASS = 2'd3
    } bank_sel_e;

    localparam logic [3:0] OFS_CTRL   = 4'd0;
    localparam logic [3:0] OFS_PG0_LO = 4'd1;
    localparam logic [3:0] OFS_PG0_HI = 4'd2;
    localparam logic [3:0] OFS_ST1    = 4'd3;
    localparam logic [3:0] OFS_ST2    = 4'd4;
    localparam logic [3:0] OFS_PG1_LO = 4'd5;
    localparam logic [3:0] OFS_PG1_HI = 4'd6;
    localparam logic [3:0] OFS_PG2_LO = 4'd7;
    localparam logic [3:0] OFS_PG2_HI = 4'd8;
endpackage

// File: rtl/wmap_regs.sv
module wmap_regs
    import wmap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [3:0]             reg_addr,
    input  logic [7:0]             wr_data,
    output logic [7:0]             rd_data,
    output logic [2:0][PAGE_W-1:0] page,
    output logic [7:0]             start1,
    output logic [7:0]             start2,
    output logic                   mem_sel,
    output logic                   restart
);
    typedef struct packed {
        logic [2:0][PAGE_W-1:0] page;
        logic [1:0][7:0]        start;
        logic                   mem_sel;
        logic                   restart;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d         = regs_q;
        regs_d.restart = 1'b0;
        rd_data        = 8'h00;
        case (reg_addr)
            OFS_CTRL:   rd_data = {7'd0, regs_q.mem_sel};
            OFS_PG0_LO: rd_data = regs_q.page[0][7:0];
            OFS_PG0_HI: rd_data = regs_q.page[0][15:8];
            OFS_ST1:    rd_data = regs_q.start[0];
            OFS_ST2:    rd_data = regs_q.start[1];
            OFS_PG1_LO: rd_data = regs_q.page[1][7:0];
            OFS_PG1_HI: rd_data = regs_q.page[1][15:8];
            OFS_PG2_LO: rd_data = regs_q.page[2][7:0];
            OFS_PG2_HI: rd_data = regs_q.page[2][15:8];
            default:    rd_data = 8'h00;
        endcase
        if (wr_en) begin
            case (reg_addr)
                OFS_CTRL: begin
                    regs_d.mem_sel = wr_data[0];
                    regs_d.restart = wr_data[0] != regs_q.mem_sel;
                end
                OFS_PG0_LO: regs_d.page[0][7:0]  = wr_data;
                OFS_PG0_HI: regs_d.page[0][15:8] = wr_data;
                OFS_ST1:    regs_d.start[0]      = wr_data;
                OFS_ST2:    regs_d.start[1]      = wr_data;
                OFS_PG1_LO: regs_d.page[1][7:0]  = wr_data;
                OFS_PG1_HI: regs_d.page[1][15:8] = wr_data;
                OFS_PG2_LO: regs_d.page[2][7:0]  = wr_data;
                OFS_PG2_HI: regs_d.page[2][15:8] = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign page    = regs_q.page;
    assign start1  = regs_q.start[0];
    assign start2  = regs_q.start[1];
    assign mem_sel = regs_q.mem_sel;
    assign restart = regs_q.restart;

    // A pulse always goes with a change of the stored select bit
    p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (mem_sel != $past(mem_sel)));
    // A change of the select bit never happens without a pulse
    p_change_has_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel != $past(mem_sel)) |-> restart);
    // Only a control write can produce a pulse
    p_pulse_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> ($past(wr_en) && $past(reg_addr) == OFS_CTRL));
endmodule

// File: rtl/wmap_xlate.sv
module wmap_xlate
    import wmap_pkg::*;
#(
    parameter int              PAGE_SHIFT = 9,
    parameter logic [VA_W-1:0] VA_LIMIT   = 16'hF000,
    localparam int             PA_W       = PAGE_W + PAGE_SHIFT + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [VA_W-1:0]        va,
    input  logic [2:0][PAGE_W-1:0] page,
    input  logic [7:0]             start1,
    input  logic [7:0]             start2,
    output logic [PA_W-1:0]        pa,
    output logic                   pa_valid,
    output bank_sel_e              bank_sel
);
    logic [2:0][VA_W-1:0] win_start;
    logic [2:0]           at_or_above;
    logic [1:0]           idx;
    logic [VA_W-1:0]      offset;

    assign win_start[0] = '0;
    assign win_start[1] = {start1[7:1], 1'b0, {(VA_W-8){1'b0}}};
    assign win_start[2] = {start2[7:1], 1'b0, {(VA_W-8){1'b0}}};

    for (genvar b = 0; b < 3; b++) begin : g_cmp
        assign at_or_above[b] = va >= win_start[b];
    end

    always_comb begin
        if (va >= VA_LIMIT)       bank_sel = SEL_PASS;
        else if (at_or_above[2])  bank_sel = SEL_B2;
        else if (at_or_above[1])  bank_sel = SEL_B1;
        else                      bank_sel = SEL_B0;
        idx    = (bank_sel == SEL_PASS) ? 2'd0 : bank_sel;
        offset = va - win_start[idx];
        if (bank_sel == SEL_PASS) begin
            pa       = PA_W'(va);
            pa_valid = 1'b0;
        end else begin
            pa       = {1'b0, page[idx], {PAGE_SHIFT{1'b0}}} + PA_W'(offset);
            pa_valid = 1'b1;
        end
    end

    p_pass_above_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (va >= VA_LIMIT) |-> (!pa_valid && pa == PA_W'(va)));
    p_valid_below_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (va < VA_LIMIT) |-> pa_valid);
    p_bank1_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel == SEL_B1) |-> (va >= win_start[1] && va < win_start[2]));
    p_bank2_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel == SEL_B2) |-> (va >= win_start[2] && va < VA_LIMIT));
    p_bank0_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel == SEL_B0) |-> (va < win_start[1] && va < win_start[2]));
endmodule

// File: rtl/window_addr_mapper.sv
module window_addr_mapper
    import wmap_pkg::*;
#(
    parameter int              PAGE_SHIFT = 9,
    parameter logic [15:0]     VA_LIMIT   = 16'hF000,
    localparam int             PA_W       = PAGE_W + PAGE_SHIFT + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [3:0]      reg_addr,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_data,
    input  logic [15:0]     va,
    output logic [PA_W-1:0] pa,
    output logic            pa_valid,
    output logic [1:0]      bank_sel,
    output logic            run_from_ram,
    output logic            restart_pulse
);
    logic [2:0][PAGE_W-1:0] page;
    logic [7:0]             start1;
    logic [7:0]             start2;
    bank_sel_e              sel;

    wmap_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .page     (page),
        .start1   (start1),
        .start2   (start2),
        .mem_sel  (run_from_ram),
        .restart  (restart_pulse)
    );

    wmap_xlate #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .VA_LIMIT   (VA_LIMIT)
    ) u_xlate (
        .clk      (clk),
        .rst_n    (rst_n),
        .va       (va),
        .page     (page),
        .start1   (start1),
        .start2   (start2),
        .pa       (pa),
        .pa_valid (pa_valid),
        .bank_sel (sel)
    );

    assign bank_sel = sel;
endmodule

// File: tb/window_addr_mapper_test.sv
module window_addr_mapper_test;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W = 26;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [7:0]      rd_data;
    logic [15:0]     va = '0;
    logic [PA_W-1:0] pa;
    logic            pa_valid;
    logic [1:0]      bank_sel;
    logic            run_from_ram;
    logic            restart_pulse;

    int checks = 0;
    int errors = 0;

    // shadow model of the programmed mapping
    logic [15:0] m_pg0 = 0, m_pg1 = 0, m_pg2 = 0;
    logic [7:0]  m_st1 = 0, m_st2 = 0;

    window_addr_mapper uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .va(va), .pa(pa),
        .pa_valid(pa_valid), .bank_sel(bank_sel),
        .run_from_ram(run_from_ram), .restart_pulse(restart_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, $sformatf("read ofs %0d", a), 32'(rd_data), 32'(exp));
    endtask

    task automatic program_map(input logic [15:0] p0, input logic [15:0] p1,
                               input logic [15:0] p2, input logic [7:0] s1,
                               input logic [7:0] s2);
        wr(4'd1, p0[7:0]); wr(4'd2, p0[15:8]);
        wr(4'd5, p1[7:0]); wr(4'd6, p1[15:8]);
        wr(4'd7, p2[7:0]); wr(4'd8, p2[15:8]);
        wr(4'd3, s1);      wr(4'd4, s2);
        m_pg0 = p0; m_pg1 = p1; m_pg2 = p2; m_st1 = s1; m_st2 = s2;
    endtask

    // expected translation from the requirements
    task automatic xlate_check(input string req, input logic [15:0] a,
                               input logic [1:0] exp_sel);
        logic [15:0]     st1, st2, base_va;
        logic [15:0]     pg;
        logic [PA_W-1:0] exp_pa;
        st1 = {m_st1[7:1], 1'b0, 8'h00};
        st2 = {m_st2[7:1], 1'b0, 8'h00};
        case (exp_sel)
            2'd0: begin pg = m_pg0; base_va = 16'h0; end
            2'd1: begin pg = m_pg1; base_va = st1; end
            default: begin pg = m_pg2; base_va = st2; end
        endcase
        if (exp_sel == 2'd3) exp_pa = PA_W'(a);
        else exp_pa = (PA_W'(pg) << 9) + PA_W'(a - base_va);
        @(negedge clk);
        va = a;
        #1;
        check(req, $sformatf("bank_sel va=%h", a), 32'(bank_sel), 32'(exp_sel));
        check(req, $sformatf("pa va=%h", a), 32'(pa), 32'(exp_pa));
        check(req, $sformatf("valid va=%h", a), 32'(pa_valid), 32'(exp_sel != 2'd3));
    endtask

    task automatic t_reset;
        for (int i = 0; i < 9; i++) rd_check("R1", 4'(i), 8'h00);
        check("R1", "run_from_ram", 32'(run_from_ram), 0);
        check("R1", "restart", 32'(restart_pulse), 0);
        xlate_check("R1", 16'h1234, 2'd2);
    endtask

    task automatic t_readback;
        for (int i = 1; i < 9; i++) wr(4'(i), 8'(8'h11 * i + 8'h05));
        for (int i = 1; i < 9; i++) rd_check("R2", 4'(i), 8'(8'h11 * i + 8'h05));
    endtask

    task automatic t_windows;
        program_map(16'h0010, 16'h0123, 16'hABCD, 8'h40, 8'h90);
        xlate_check("R4", 16'h0000, 2'd0);
        xlate_check("R4", 16'h3FFF, 2'd0);
        xlate_check("R5", 16'h4000, 2'd1);
        xlate_check("R5", 16'h8FFF, 2'd1);
        xlate_check("R6", 16'h9000, 2'd2);
        xlate_check("R6", 16'hEFFF, 2'd2);
        xlate_check("R8", 16'hF000, 2'd3);
        xlate_check("R8", 16'hFFFF, 2'd3);
    endtask

    task automatic t_start_bit0;
        program_map(16'h0010, 16'h0123, 16'hABCD, 8'h41, 8'h91);
        xlate_check("R3", 16'h4000, 2'd1);
        xlate_check("R3", 16'h40FF, 2'd1);
        xlate_check("R3", 16'h9000, 2'd2);
        xlate_check("R3", 16'h3FFF, 2'd0);
    endtask

    task automatic t_overlap;
        program_map(16'h0002, 16'h0300, 16'h7777, 8'hA0, 8'h60);
        xlate_check("R7", 16'h5000, 2'd0);
        xlate_check("R7", 16'h6000, 2'd2);
        xlate_check("R7", 16'hB000, 2'd2);
        program_map(16'h0002, 16'h0300, 16'h7777, 8'h60, 8'h60);
        xlate_check("R7", 16'h5FFF, 2'd0);
        xlate_check("R7", 16'h6000, 2'd2);
    endtask

    task automatic t_restart;
        wr(4'd0, 8'h01);
        check("R9", "pulse on 0->1", 32'(restart_pulse), 1);
        check("R9", "sel after 0->1", 32'(run_from_ram), 1);
        @(negedge clk);
        check("R9", "pulse one cycle", 32'(restart_pulse), 0);
        wr(4'd0, 8'hFF);
        check("R9", "no pulse same bit", 32'(restart_pulse), 0);
        wr(4'd0, 8'h00);
        check("R9", "pulse on 1->0", 32'(restart_pulse), 1);
        check("R9", "sel after 1->0", 32'(run_from_ram), 0);
        @(negedge clk);
        check("R9", "pulse cleared", 32'(restart_pulse), 0);
    endtask

    task automatic t_unmapped;
        program_map(16'h00A5, 16'h015A, 16'h0F0F, 8'h20, 8'hC0);
        for (int i = 9; i < 16; i++) begin
            wr(4'(i), 8'hFF);
            check("R10", "no restart", 32'(restart_pulse), 0);
            rd_check("R10", 4'(i), 8'h00);
        end
        rd_check("R10", 4'd0, 8'h00);
        rd_check("R10", 4'd1, 8'hA5);
        rd_check("R10", 4'd4, 8'hC0);
        rd_check("R10", 4'd8, 8'h0F);
        xlate_check("R10", 16'h2100, 2'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 2);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_windows();
        t_start_bit0();
        t_overlap();
        t_restart();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule